// File: doc/BRIEF.md
# Board Configuration Transaction Controller

This block turns three memory-mapped words into a small command engine for board configuration. Software places an operand in the data word. It then writes the control word with the launch bit set. The written control value names a function, a site, a position and a device. The block decodes these fields and carries out the transaction against local tables on the same clock edge as the write. It records the outcome in a two-bit status word: bit 0 means complete and bit 1 means error.

The block keeps two oscillator tables. The motherboard table has six entries. The daughterboard table's depth is a parameter. A daughterboard voltage table and a fixed motherboard supply reading are also provided. Both oscillator tables can be read and written. The voltage values are read-only.

Two functions request a board shutdown or a board restart. Each request appears as a single-cycle pulse, produced by a three-state machine:
- `ST_IDLE` is the resting state.
- `ST_SHUT` asserts `cfg_shutdown`.
- `ST_RBT` asserts `cfg_reboot`.

The transitions are as follows:
- A successful shutdown launch moves the machine to `ST_SHUT`.
- A successful reboot launch moves it to `ST_RBT`.
- Every other cycle returns it to `ST_IDLE`. This includes the cycle after either pulse state.

Top module: `cfg_txn_ctrl`

## Requirements
- R1: After reset, the data, control and status words all read 0. Both pulse outputs are low.
- R2: The data word at offset 0xA0 stores any written value. The control word at 0xA4 stores the written value with bit 31 and bits 19:18 forced to zero. The control field layout is:
  - bit 31: launch
  - bit 30: direction (1 = write, 0 = read)
  - bits 29:26: channel (DCC)
  - bits 25:20: function
  - bits 17:16: site
  - bits 15:12: position
  - bits 11:0: device
- R3: A control write with bit 31 set makes the status word at 0xA8 read 1 or 3 from the next cycle. A control write with bit 31 clear leaves the status word and all tables unchanged.
- R4: A launched transaction with a non-zero DCC, a non-zero position, or site 2 or 3 sets status to 3 (complete and error).
- R5: A read with function 1 copies an oscillator entry into the data word.
  - Site 0 selects motherboard entry `device` when device < 6.
  - Site 1 selects daughterboard entry `device` when device < DB_CLOCKS. The daughterboard resets to 60000000, 40000000, 30000000 and 20000000 for entries 0 to 3 by default.
  - Any other index gives status 3 and leaves the data word unchanged.
- R6: The motherboard oscillator entries reset to 50000000 (entry 0), 23750000 (entry 1) and 24000000 (entries 2 to 5).
- R7: A write with function 1 stores the current data word into the indexed oscillator entry, using the same index rules as R5. A later read returns the stored value.
- R8: A read with function 2 returns 3300000 for site 0, device 0. For site 1 it returns daughterboard voltage entry `device` when device < DB_VSENS; the defaults are 900000, 1000000, 1100000 and 1200000. Every write with function 2, and every other function 2 index, gives status 3.
- R9: The following apply only to writes at site 0, device 0:
  - Function 8 raises `cfg_shutdown` for exactly the cycle after the launch edge.
  - Function 9 does the same on `cfg_reboot`.
  - Functions 7 and 11 complete without error and have no effect.
  - Any other function, direction or index gives status 3 and no pulse.
- R10: A direct write to the status word stores only bits 1:0 of the written value.
- R11: Reads of any offset other than 0xA0, 0xA4 and 0xA8 return 0. Writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cfg_shutdown | output | 1 | One-cycle shutdown request |
| cfg_reboot | output | 1 | One-cycle restart request |

## Verification
Table contents are visible at the ports only through a launched read. A corrupted oscillator entry therefore stays hidden until software reads that index back, and then appears in the data word one cycle after the launch. A wrong decode shows in the status word on the cycle after the control write: a legal route reads 3, or an illegal one reads 1. A mis-steered state machine shows as a pulse that is missing, doubled or on the wrong output in that same cycle. For these reasons the bench reads the data, control and status words back after every transaction and checks both pulse outputs after every write.

// File: rtl/cfg_txn_pkg.sv
package cfg_txn_pkg;

    localparam int CFG_AW = 8;

    localparam logic [CFG_AW-1:0] OFS_DATA = 8'hA0;
    localparam logic [CFG_AW-1:0] OFS_CTRL = 8'hA4;
    localparam logic [CFG_AW-1:0] OFS_STAT = 8'hA8;

    // bits dropped when the control word is stored: launch and 19:18
    localparam logic [31:0] CTRL_KEEP = 32'h7FF3_FFFF;

    localparam logic [5:0] FN_OSC  = 6'd1;
    localparam logic [5:0] FN_VOLT = 6'd2;
    localparam logic [5:0] FN_MUX  = 6'd7;
    localparam logic [5:0] FN_SHUT = 6'd8;
    localparam logic [5:0] FN_RBT  = 6'd9;
    localparam logic [5:0] FN_DVI  = 6'd11;

    localparam logic [31:0] MB_SUPPLY_UV = 32'd3300000;

    typedef struct packed {
        logic        start;
        logic        wr;
        logic [3:0]  dcc;
        logic [5:0]  fn;
        logic [1:0]  rsvd;
        logic [1:0]  site;
        logic [3:0]  pos;
        logic [11:0] dev;
    } cfg_cmd_t;

    typedef enum logic [2:0] {
        TGT_ERR,
        TGT_MB_CLK,
        TGT_DB_CLK,
        TGT_MB_VOLT,
        TGT_DB_VOLT,
        TGT_NOP,
        TGT_SHUT,
        TGT_RBT
    } cfg_tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHUT,
        ST_RBT
    } cfg_state_e;

endpackage

// File: rtl/cfg_txn_decode.sv
module cfg_txn_decode
    import cfg_txn_pkg::*;
#(
    parameter int MB_CLOCKS = 6,
    parameter int DB_CLOCKS = 4,
    parameter int DB_VSENS  = 4
) (
    input  logic [31:0] cmd_word,
    output cfg_tgt_e    tgt,
    output logic        is_wr
);
    localparam logic [11:0] MB_LIM = 12'(MB_CLOCKS);
    localparam logic [11:0] DB_LIM = 12'(DB_CLOCKS);
    localparam logic [11:0] DV_LIM = 12'(DB_VSENS);

    cfg_cmd_t c;
    logic     route_ok;
    logic     mb_dev0;
    logic     unused_bits;

    assign c           = cfg_cmd_t'(cmd_word);
    assign is_wr       = c.wr;
    assign unused_bits = ^{c.start, c.rsvd};
    assign route_ok    = (c.dcc == 4'd0) && (c.pos == 4'd0) && !c.site[1];
    assign mb_dev0     = (c.site == 2'd0) && (c.dev == 12'd0);

    always_comb begin
        tgt = TGT_ERR;
        if (route_ok) begin
            case (c.fn)
                FN_OSC: begin
                    if (c.site == 2'd0 && c.dev < MB_LIM)      tgt = TGT_MB_CLK;
                    else if (c.site == 2'd1 && c.dev < DB_LIM) tgt = TGT_DB_CLK;
                end
                FN_VOLT: begin
                    if (!c.wr && mb_dev0)                                tgt = TGT_MB_VOLT;
                    else if (!c.wr && c.site == 2'd1 && c.dev < DV_LIM)  tgt = TGT_DB_VOLT;
                end
                FN_MUX, FN_DVI: if (c.wr && mb_dev0) tgt = TGT_NOP;
                FN_SHUT:        if (c.wr && mb_dev0) tgt = TGT_SHUT;
                FN_RBT:         if (c.wr && mb_dev0) tgt = TGT_RBT;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_osc_bank.sv
module cfg_osc_bank #(
    parameter int                    DEPTH = 4,
    parameter logic [DEPTH*32-1:0]   INIT  = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [11:0] idx,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data
);
    logic [31:0] ent_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent_q[i] <= INIT[i*32 +: 32];
            else if (wr_en && idx == 12'(i))
                ent_q[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++)
            if (idx == 12'(i)) rd_data = ent_q[i];
    end
endmodule

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl
    import cfg_txn_pkg::*;
#(
    parameter int                      DB_CLOCKS   = 4,
    parameter int                      DB_VSENS    = 4,
    parameter logic [DB_CLOCKS*32-1:0] DB_CLK_INIT = {32'd20000000, 32'd30000000,
                                                      32'd40000000, 32'd60000000},
    parameter logic [DB_VSENS*32-1:0]  DB_VOLT_UV  = {32'd1200000, 32'd1100000,
                                                      32'd1000000, 32'd900000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [CFG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              cfg_shutdown,
    output logic              cfg_reboot
);
    localparam int MB_CLOCKS = 6;
    localparam logic [MB_CLOCKS*32-1:0] MB_INIT = {32'd24000000, 32'd24000000,
                                                   32'd24000000, 32'd24000000,
                                                   32'd23750000, 32'd50000000};

    logic [31:0] data_q, ctrl_q;
    logic [1:0]  stat_q;
    cfg_state_e  state_q, state_d;

    logic        wr_data, wr_ctrl, wr_stat, launch;
    cfg_tgt_e    tgt;
    logic        is_wr;
    logic [11:0] dev;
    logic [31:0] mb_rd, db_rd, dv_rd, rd_result;

    assign wr_data = reg_wr && reg_addr == OFS_DATA;
    assign wr_ctrl = reg_wr && reg_addr == OFS_CTRL;
    assign wr_stat = reg_wr && reg_addr == OFS_STAT;
    assign launch  = wr_ctrl && reg_wdata[31];
    assign dev     = reg_wdata[11:0];

    cfg_txn_decode #(
        .MB_CLOCKS(MB_CLOCKS), .DB_CLOCKS(DB_CLOCKS), .DB_VSENS(DB_VSENS)
    ) u_dec (
        .cmd_word(reg_wdata), .tgt(tgt), .is_wr(is_wr)
    );

    cfg_osc_bank #(.DEPTH(MB_CLOCKS), .INIT(MB_INIT)) u_mb_osc (
        .clk(clk), .rst_n(rst_n),
        .wr_en(launch && is_wr && tgt == TGT_MB_CLK),
        .idx(dev), .wr_data(data_q), .rd_data(mb_rd)
    );

    cfg_osc_bank #(.DEPTH(DB_CLOCKS), .INIT(DB_CLK_INIT)) u_db_osc (
        .clk(clk), .rst_n(rst_n),
        .wr_en(launch && is_wr && tgt == TGT_DB_CLK),
        .idx(dev), .wr_data(data_q), .rd_data(db_rd)
    );

    always_comb begin
        dv_rd = '0;
        for (int i = 0; i < DB_VSENS; i++)
            if (dev == 12'(i)) dv_rd = DB_VOLT_UV[i*32 +: 32];
    end

    always_comb begin
        case (tgt)
            TGT_MB_CLK:  rd_result = mb_rd;
            TGT_DB_CLK:  rd_result = db_rd;
            TGT_MB_VOLT: rd_result = MB_SUPPLY_UV;
            TGT_DB_VOLT: rd_result = dv_rd;
            default:     rd_result = '0;
        endcase
    end

    // register file: transaction completes on the control-write edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            if (wr_data) data_q <= reg_wdata;
            if (wr_stat) stat_q <= reg_wdata[1:0];
            if (wr_ctrl) begin
                ctrl_q <= reg_wdata & CTRL_KEEP;
                if (reg_wdata[31]) begin
                    stat_q <= {tgt == TGT_ERR, 1'b1};
                    if (!is_wr && tgt != TGT_ERR) data_q <= rd_result;
                end
            end
        end
    end

    // request sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: a pulse state is always left after one cycle
    always_comb begin
        state_d = ST_IDLE;
        if (launch) begin
            case (tgt)
                TGT_SHUT: state_d = ST_SHUT;
                TGT_RBT:  state_d = ST_RBT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        cfg_shutdown = 1'b0;
        cfg_reboot   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SHUT: cfg_shutdown = 1'b1;
            ST_RBT:  cfg_reboot   = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        case (reg_addr)
            OFS_DATA: reg_rdata = data_q;
            OFS_CTRL: reg_rdata = ctrl_q;
            OFS_STAT: reg_rdata = {30'd0, stat_q};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfg_txn_ctrl_chk.sv
module cfg_txn_ctrl_chk
    import cfg_txn_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [CFG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              cfg_shutdown,
    input logic              cfg_reboot,
    input logic [1:0]        stat_q
);
    logic ctrl_wr, start;
    assign ctrl_wr = reg_wr && reg_addr == OFS_CTRL;
    assign start   = ctrl_wr && reg_wdata[31];

    AST_CTRL_RSVD_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_CTRL) |-> (!reg_rdata[31] && reg_rdata[19:18] == 2'b00)); // R2

    AST_START_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> stat_q[0]); // R3

    AST_NOSTART_STAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !reg_wdata[31]) |=> $stable(stat_q)); // R3

    AST_BAD_ROUTE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (reg_wdata[29:26] != 4'd0 || reg_wdata[15:12] != 4'd0 || reg_wdata[17]))
        |=> stat_q == 2'b11); // R4

    AST_STAT_LOW2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_STAT) |=> stat_q == $past(reg_wdata[1:0])); // R10

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_shutdown && cfg_reboot)); // R9

    AST_SHUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shutdown |-> $past(start && reg_wdata[30] && reg_wdata[25:20] == FN_SHUT)); // R9

    AST_RBT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reboot |-> $past(start && reg_wdata[30] && reg_wdata[25:20] == FN_RBT)); // R9

    AST_UNMAPPED_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != OFS_DATA && reg_addr != OFS_CTRL && reg_addr != OFS_STAT)
        |-> reg_rdata == 32'd0); // R11
endmodule

bind cfg_txn_ctrl cfg_txn_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_shutdown(cfg_shutdown),
    .cfg_reboot(cfg_reboot), .stat_q(stat_q)
);

// File: tb/cfg_txn_ctrl_bench.sv
module cfg_txn_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cfg_shutdown, cfg_reboot;

    always #5 clk = ~clk;

    cfg_txn_ctrl u_cfg_txn_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_shutdown(cfg_shutdown), .cfg_reboot(cfg_reboot)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model
    logic [31:0] m_data, m_ctrl;
    logic [1:0]  m_stat;
    logic [31:0] m_mb [6];
    logic [31:0] m_db [4];
    logic [31:0] m_dv [4];
    logic        e_shut, e_rbt;

    function automatic logic [31:0] mk(input bit wr, input int dcc, input int fn,
                                       input int site, input int pos, input int dev);
        return {1'b1, wr, 4'(dcc), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_data = 0; m_ctrl = 0; m_stat = 0; e_shut = 0; e_rbt = 0;
        m_mb[0] = 32'd50000000; m_mb[1] = 32'd23750000;
        for (int i = 2; i < 6; i++) m_mb[i] = 32'd24000000;
        m_db[0] = 32'd60000000; m_db[1] = 32'd40000000;
        m_db[2] = 32'd30000000; m_db[3] = 32'd20000000;
        m_dv[0] = 32'd900000;  m_dv[1] = 32'd1000000;
        m_dv[2] = 32'd1100000; m_dv[3] = 32'd1200000;
    endtask

    task automatic model_ctrl(input logic [31:0] w);
        bit ok = 0;
        logic [31:0] rv = 0;
        bit wr = w[30];
        int dcc = int'(w[29:26]), fn = int'(w[25:20]), site = int'(w[17:16]);
        int pos = int'(w[15:12]), dev = int'(w[11:0]);
        m_ctrl = w & 32'h7FF3_FFFF;
        if (!w[31]) return;
        if (dcc == 0 && pos == 0 && site < 2) begin
            case (fn)
                1: if (site == 0 && dev < 6) begin
                       ok = 1; if (wr) m_mb[dev] = m_data; else rv = m_mb[dev];
                   end else if (site == 1 && dev < 4) begin
                       ok = 1; if (wr) m_db[dev] = m_data; else rv = m_db[dev];
                   end
                2: if (!wr && site == 0 && dev == 0) begin ok = 1; rv = 32'd3300000; end
                   else if (!wr && site == 1 && dev < 4) begin ok = 1; rv = m_dv[dev]; end
                7, 11: if (wr && site == 0 && dev == 0) ok = 1;
                8: if (wr && site == 0 && dev == 0) begin ok = 1; e_shut = 1; end
                9: if (wr && site == 0 && dev == 0) begin ok = 1; e_rbt = 1; end
                default: ;
            endcase
        end
        m_stat = {!ok, 1'b1};
        if (ok && !wr) m_data = rv;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        e_shut = 0; e_rbt = 0;
        case (a)
            8'hA0: m_data = d;
            8'hA4: model_ctrl(d);
            8'hA8: m_stat = d[1:0];
            default: ;
        endcase
        chk("R9 shutdown pulse", {31'd0, cfg_shutdown}, {31'd0, e_shut});
        chk("R9 reboot pulse",   {31'd0, cfg_reboot},   {31'd0, e_rbt});
        @(negedge clk);
        chk("R9 pulse single cycle", {30'd0, cfg_shutdown, cfg_reboot}, 32'd0);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        rd_chk({tag, " data"}, 8'hA0, m_data);
        rd_chk({tag, " ctrl"}, 8'hA4, m_ctrl);
        rd_chk({tag, " stat"}, 8'hA8, {30'd0, m_stat});
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check_all("R1");
        chk("R1 pulses idle", {30'd0, cfg_shutdown, cfg_reboot}, 32'd0);
        // R11 unmapped
        @(negedge clk);
        rd_chk("R11 unmapped 0x04", 8'h04, 0);
        rd_chk("R11 unmapped 0xFC", 8'hFC, 0);
        wr(8'h10, 32'hDEAD_BEEF);
        check_all("R11 write ignored");
        // R2 / R3 storage without launch
        wr(8'hA0, 32'hCAFE_F00D);
        wr(8'hA4, 32'h7FFF_FFFF);
        check_all("R2 R3 ctrl store no launch");
        // R6 motherboard reset values, R5 reads
        for (int i = 0; i < 6; i++) begin
            wr(8'hA4, mk(0, 0, 1, 0, 0, i));
            check_all("R6 mb osc read");
        end
        for (int i = 0; i < 4; i++) begin
            wr(8'hA4, mk(0, 0, 1, 1, 0, i));
            check_all("R5 db osc read");
        end
        wr(8'hA4, mk(0, 0, 1, 0, 0, 6));
        check_all("R5 mb index out of range");
        wr(8'hA4, mk(0, 0, 1, 1, 0, 4));
        check_all("R5 db index out of range");
        // R7 writes then readback
        wr(8'hA0, 32'h0123_4567);
        wr(8'hA4, mk(1, 0, 1, 0, 0, 2));
        wr(8'hA0, 32'h0);
        wr(8'hA4, mk(0, 0, 1, 0, 0, 2));
        check_all("R7 mb write readback");
        wr(8'hA0, 32'h89AB_CDEF);
        wr(8'hA4, mk(1, 0, 1, 1, 0, 3));
        wr(8'hA4, mk(0, 0, 1, 1, 0, 3));
        check_all("R7 db write readback");
        // R8 voltages
        wr(8'hA4, mk(0, 0, 2, 0, 0, 0));
        check_all("R8 mb supply");
        for (int i = 0; i < 4; i++) begin
            wr(8'hA4, mk(0, 0, 2, 1, 0, i));
            check_all("R8 db voltage");
        end
        wr(8'hA4, mk(1, 0, 2, 1, 0, 0));
        check_all("R8 voltage write rejected");
        wr(8'hA4, mk(0, 0, 2, 0, 0, 1));
        check_all("R8 mb voltage bad index");
        // R9 control functions
        wr(8'hA4, mk(1, 0, 8, 0, 0, 0));
        check_all("R9 shutdown");
        wr(8'hA4, mk(1, 0, 9, 0, 0, 0));
        check_all("R9 reboot");
        wr(8'hA4, mk(1, 0, 7, 0, 0, 0));
        check_all("R9 fn7 accepted");
        wr(8'hA4, mk(1, 0, 11, 0, 0, 0));
        check_all("R9 fn11 accepted");
        wr(8'hA4, mk(1, 0, 8, 1, 0, 0));
        check_all("R9 shutdown wrong site");
        wr(8'hA4, mk(0, 0, 9, 0, 0, 0));
        check_all("R9 reboot as read");
        wr(8'hA4, mk(1, 0, 5, 0, 0, 0));
        check_all("R9 unknown function");
        // R4 routing errors
        wr(8'hA4, mk(0, 1, 1, 0, 0, 0));
        check_all("R4 dcc nonzero");
        wr(8'hA4, mk(0, 0, 1, 0, 1, 0));
        check_all("R4 position nonzero");
        wr(8'hA4, mk(0, 0, 1, 2, 0, 0));
        check_all("R4 site 2");
        wr(8'hA4, mk(0, 0, 1, 3, 0, 0));
        check_all("R4 site 3");
        // R10 direct status write
        wr(8'hA8, 32'hFFFF_FFFE);
        check_all("R10 status low bits");
        wr(8'hA8, 32'h0000_0005);
        check_all("R10 status low bits 2");
        // random mix
        for (int n = 0; n < 400; n++) begin
            int k = int'($urandom_range(0, 9));
            if (k == 0) wr(8'hA0, $urandom());
            else if (k == 1) wr(8'hA8, $urandom());
            else begin
                int fsel = int'($urandom_range(0, 7));
                int fn;
                logic [31:0] w;
                case (fsel)
                    0, 1: fn = 1;
                    2: fn = 2;
                    3: fn = 7;
                    4: fn = 8;
                    5: fn = 9;
                    6: fn = 11;
                    default: fn = int'($urandom_range(0, 63));
                endcase
                w = mk($urandom_range(0, 1) == 1,
                       ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 15)) : 0,
                       fn, int'($urandom_range(0, 3)),
                       ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 15)) : 0,
                       int'($urandom_range(0, 7)));
                if ($urandom_range(0, 9) == 0) w[31] = 1'b0;
                w[19:18] = 2'($urandom_range(0, 3));
                wr(8'hA4, w);
            end
            check_all("R3 R5 R7 random");
        end
        done = 1;
        report();
    end
endmodule